// File: doc/BRIEF.md
# Bus-Master Handover Control Flag

This block sits on a host computer's expansion bus and decides when the host CPU must give up its buses to an outside master. It drives one active-low DMA request line. When that line is low, the host CPU tri-states its address, data and control buses, and another agent can then reach the host's memory.

One peripheral-select line marks accesses to a single I/O page. Three address bits split that page into eight strobes, so other functions can share the page. Strobe 0 is the "acquire" command and strobe 1 is the "release" command. An access to either one, read or write, records the command.

The request line must only move at a safe moment: in the low half of the host phase-2 clock, and never while the CPU is writing. A command seen at any other time is held pending. It is applied at the first safe point, and a newer command replaces an older one that has not yet been applied. The block runs on a fast system clock and samples phase-2 through a synchroniser. A status output tells the transfer logic when the host bus can be treated as granted.

Top module: `dma_handover_ctrl`

## Requirements
- R1: After reset, and on the first clock after reset is released, `dma_req_n` is 1 and `bus_granted` is 0. A reset in the middle of operation also releases the request.
- R2: With `io_sel` high, address bits [SUB_LSB+2:SUB_LSB] (bits 7:5 by default) select a command. Code 0 requests DMA (`dma_req_n` goes to 0). Code 1 releases it (`dma_req_n` goes to 1). The address bits below SUB_LSB have no effect.
- R3: Codes 2 to 7, and any access with `io_sel` low, leave `dma_req_n` unchanged.
- R4: `dma_req_n` changes only on a clock edge where the synchronised phase-2 is low. A command given while phase-2 is high is held and applied in the next phase-2 low interval.
- R5: `dma_req_n` never changes while `rw_n` is 0 (host write). A pending command waits until `rw_n` is 1 during a low phase.
- R6: A command replaces any command still pending. Of two commands given in one high phase, only the second takes effect.
- R7: `bus_granted` rises on the first clock that sees phase-2 high after the request went low. It falls on the same clock edge on which `dma_req_n` returns to 1. It is never 1 while `dma_req_n` is 1.
- R8: `page_strobe` is the one-hot decode of the three command bits while `io_sel` is high (bit n set for code n), and all zeros while `io_sel` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than phase-2 |
| rst | input | 1 | Synchronous active-high reset |
| phi2 | input | 1 | Host phase-2 clock (asynchronous; synchronised inside) |
| rw_n | input | 1 | Host read/write: 1 = read, 0 = write |
| io_sel | input | 1 | Peripheral select for the shared I/O page |
| addr | input | ADDR_W (8) | Host address bits inside the page |
| page_strobe | output | 2**SUB_BITS (8) | One-hot sub-decode of the page |
| dma_req_n | output | 1 | Active-low DMA request to the host |
| bus_granted | output | 1 | High while the host bus may be used by the outside master |

## Verification
The assertions check every cycle that the request never moves outside a synchronised low phase or during a write. They also check that the request is released right after reset, that ignored codes cannot move the line when nothing is pending, and that the grant status only rises out of a high phase and never appears without a request. Some behaviour only the bench's scenarios can show: the full command path through the decode, with low address bits set; a command held through a high phase and then applied; the wait through a write-time low phase; the "last command wins" ordering; and the exact one-hot strobe patterns.

// File: rtl/hof_pkg.sv
package hof_pkg;
  typedef enum logic [1:0] {
    CMD_NONE    = 2'd0,
    CMD_ACQUIRE = 2'd1,
    CMD_RELEASE = 2'd2
  } hof_cmd_e;
endpackage

// File: rtl/hof_page_decode.sv
module hof_page_decode
  import hof_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int SUB_LSB  = 5,
  parameter int SUB_BITS = 3,
  parameter int ACQ_IDX  = 0,
  parameter int REL_IDX  = 1
) (
  input  logic                       sel,
  input  logic [ADDR_W-1:0]          addr,
  output logic [(1<<SUB_BITS)-1:0]   strobe,
  output hof_cmd_e                   cmd
);
  localparam int STROBES = 1 << SUB_BITS;

  logic [SUB_BITS-1:0] code;
  assign code = addr[SUB_LSB +: SUB_BITS];

  for (genvar i = 0; i < STROBES; i++) begin : g_strobe
    assign strobe[i] = sel && (code == SUB_BITS'(i));
  end

  always_comb begin
    if (strobe[ACQ_IDX])      cmd = CMD_ACQUIRE;
    else if (strobe[REL_IDX]) cmd = CMD_RELEASE;
    else                      cmd = CMD_NONE;
  end
endmodule

// File: rtl/hof_sync.sv
module hof_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hof_flag.sv
module hof_flag
  import hof_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     phi2_s,
  input  logic     rw_n,
  input  hof_cmd_e cmd,
  output logic     dma_n,
  output logic     granted
);
  hof_cmd_e pend, pend_nxt;
  logic     flag, flag_nxt, safe;

  assign safe = !phi2_s && rw_n;

  always_comb begin
    pend_nxt = (cmd != CMD_NONE) ? cmd : pend;
    flag_nxt = flag;
    if (safe && pend_nxt == CMD_ACQUIRE) flag_nxt = 1'b0;
    if (safe && pend_nxt == CMD_RELEASE) flag_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag    <= 1'b1;
      pend    <= CMD_NONE;
      granted <= 1'b0;
    end else begin
      flag    <= flag_nxt;
      pend    <= safe ? CMD_NONE : pend_nxt;
      granted <= !flag_nxt && (granted || phi2_s);
    end
  end

  assign dma_n = flag;

  assert_reset_release_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (flag && !granted));

  assert_change_in_low_R4: assert property (@(posedge clk) disable iff (rst)
    (flag != $past(flag)) |-> !$past(phi2_s));

  assert_no_change_write_R5: assert property (@(posedge clk) disable iff (rst)
    (flag != $past(flag)) |-> $past(rw_n));

  assert_ignored_codes_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_NONE && pend == CMD_NONE) |=> $stable(flag));

  assert_grant_needs_req_R7: assert property (@(posedge clk) disable iff (rst)
    granted |-> !flag);

  assert_grant_from_high_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(granted) |-> $past(phi2_s));
endmodule

// File: rtl/dma_handover_ctrl.sv
module dma_handover_ctrl
  import hof_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SUB_LSB     = 5,
  parameter int SUB_BITS    = 3,
  parameter int ACQ_IDX     = 0,
  parameter int REL_IDX     = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     phi2,
  input  logic                     rw_n,
  input  logic                     io_sel,
  input  logic [ADDR_W-1:0]        addr,
  output logic [(1<<SUB_BITS)-1:0] page_strobe,
  output logic                     dma_req_n,
  output logic                     bus_granted
);
  hof_cmd_e cmd;
  logic     phi2_s;

  hof_page_decode #(
    .ADDR_W(ADDR_W), .SUB_LSB(SUB_LSB), .SUB_BITS(SUB_BITS),
    .ACQ_IDX(ACQ_IDX), .REL_IDX(REL_IDX)
  ) u_dec (
    .sel(io_sel), .addr(addr), .strobe(page_strobe), .cmd(cmd)
  );

  hof_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(phi2), .q(phi2_s)
  );

  hof_flag u_flag (
    .clk(clk), .rst(rst), .phi2_s(phi2_s), .rw_n(rw_n), .cmd(cmd),
    .dma_n(dma_req_n), .granted(bus_granted)
  );

  assert_strobe_select_R8: assert property (@(posedge clk) disable iff (rst)
    !io_sel |-> (page_strobe == '0));
endmodule

// File: tb/sim_dma_handover_ctrl.sv
module sim_dma_handover_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       phi2 = 1'b1;
  logic       rw_n = 1'b1;
  logic       io_sel = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] page_strobe;
  logic       dma_req_n, bus_granted;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  dma_handover_ctrl u0 (
    .clk(clk), .rst(rst), .phi2(phi2), .rw_n(rw_n), .io_sel(io_sel),
    .addr(addr), .page_strobe(page_strobe), .dma_req_n(dma_req_n),
    .bus_granted(bus_granted)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_phase(input logic lvl, input int n);
    @(negedge clk);
    phi2 = lvl;
    wait_clk(n);
  endtask

  // One-clock access to the page; checks the strobe decode (R8)
  task automatic access(input logic [7:0] a, input logic sel_v);
    @(negedge clk);
    addr = a; io_sel = sel_v;
    #1;
    chk("R8 strobe", page_strobe, sel_v ? (8'h01 << a[7:5]) : 8'h00);
    @(negedge clk);
    io_sel = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 dma_req_n after reset", {7'b0, dma_req_n}, 8'h01);
    chk("R1 granted after reset", {7'b0, bus_granted}, 8'h00);
  endtask

  task automatic t_acquire;
    access(8'h1F, 1'b1);                 // code 0, low bits set
    wait_clk(5);
    chk("R4 held in high phase", {7'b0, dma_req_n}, 8'h01);
    set_phase(1'b0, 6);
    chk("R2 acquire", {7'b0, dma_req_n}, 8'h00);
    chk("R7 no grant in low", {7'b0, bus_granted}, 8'h00);
    set_phase(1'b1, 5);
    chk("R7 grant in high", {7'b0, bus_granted}, 8'h01);
  endtask

  task automatic t_release;
    access(8'h3A, 1'b1);                 // code 1
    wait_clk(5);
    chk("R4 release held", {7'b0, dma_req_n}, 8'h00);
    chk("R7 grant kept", {7'b0, bus_granted}, 8'h01);
    set_phase(1'b0, 6);
    chk("R2 release", {7'b0, dma_req_n}, 8'h01);
    chk("R7 grant dropped", {7'b0, bus_granted}, 8'h00);
    set_phase(1'b1, 5);
  endtask

  task automatic t_write_block;
    access(8'h00, 1'b1);
    @(negedge clk); rw_n = 1'b0;
    set_phase(1'b0, 8);
    chk("R5 no change during write", {7'b0, dma_req_n}, 8'h01);
    @(negedge clk); rw_n = 1'b1;
    wait_clk(3);
    chk("R5 applied after write", {7'b0, dma_req_n}, 8'h00);
    set_phase(1'b1, 5);
    t_release();
  endtask

  task automatic t_ignored;
    for (int c = 2; c < 8; c++) access(8'(c << 5), 1'b1);
    access(8'h00, 1'b0);                 // code 0 without select
    wait_clk(4);
    set_phase(1'b0, 6);
    chk("R3 ignored codes", {7'b0, dma_req_n}, 8'h01);
    set_phase(1'b1, 5);
    chk("R3 no grant", {7'b0, bus_granted}, 8'h00);
  endtask

  task automatic t_replace;
    access(8'h00, 1'b1);
    access(8'h20, 1'b1);
    set_phase(1'b0, 6);
    chk("R6 release replaces acquire", {7'b0, dma_req_n}, 8'h01);
    set_phase(1'b1, 5);
    access(8'h20, 1'b1);
    access(8'h00, 1'b1);
    set_phase(1'b0, 6);
    chk("R6 acquire replaces release", {7'b0, dma_req_n}, 8'h00);
    set_phase(1'b1, 5);
  endtask

  task automatic t_reset_mid;
    @(negedge clk); rst = 1'b1;
    wait_clk(2);
    rst = 1'b0;
    wait_clk(1);
    chk("R1 reset mid operation", {7'b0, dma_req_n}, 8'h01);
    chk("R1 grant cleared", {7'b0, bus_granted}, 8'h00);
  endtask

  initial begin
    wait_clk(4);
    rst = 1'b0;
    wait_clk(4);
    t_reset();
    t_acquire();
    t_release();
    t_write_block();
    t_ignored();
    t_replace();
    t_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule